// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between one processor and the interrupt source side of a chip. It holds one presented interrupt at a time. It decides by priority whether a newly offered source displaces the one already held, and it drives a level interrupt line to the processor. Any source it turns away goes back to the source side on a reject strobe, tagged with the number and the owner id of that source. The source side replays such a source when the presenter raises a resend request.

Software works on the presenter through a small set of operations:
- Accept takes the held interrupt and raises the processor priority to it.
- Set-priority changes the processor priority.
- Set-IPI-priority posts an inter-processor interrupt.
- End-of-interrupt restores a priority and signals completion to the source side.
- Poll reads the state without changing it.

Lower numbers are more favoured, and the all-ones priority means "none". Every result appears on the outputs one clock after the operation or request is presented.

Top module: `intPresenter`

## Requirements
- R1: After reset the status word reads 0x00000000, the IPI priority reads 0xFF, the irq line is low, and the pending priority is 0xFF. An accept issued straight after reset returns 0 and then leaves 0xFF000000 in the status word.
- R2: The status word carries the processor priority in bits 31:24 and the pending source number in bits 23:0. Source number 0 means nothing is pending. The irq line is high exactly when the source number is non-zero, and the pending priority is 0xFF whenever it is zero.
- R3: A request whose priority is below the processor priority, and below any pending priority, is latched: the number is stored, the irq line goes high, and the owner is recorded. A pending source that came from the source side is rejected with its own number and owner. A pending IPI is dropped without any reject.
- R4: A request whose priority is greater than or equal to the processor priority, or greater than or equal to the pending priority, is rejected with its own number and owner. The state is left unchanged.
- R5: Accept (op 1) returns the old status word on rdData and lowers the line. It loads the processor priority with the pending priority, clears the number and sets the pending priority to 0xFF.
- R6: Set-priority (op 2, value in swData[7:0]) with a lower value that is also less than or equal to the pending priority rejects an owned pending source, clears it and lowers the line. A lower value above the pending priority only updates the priority.
- R7: Set-priority with an equal or higher value while nothing is pending pulses resendReq. In the same step, if the IPI priority is below the new value, the IPI (source number 2) is made pending.
- R8: Set-IPI-priority (op 3, value in swData[7:0]) with a value below the processor priority makes source 2 pending at that priority and rejects an owned pending source. It does neither if a pending priority is less than or equal to the new value. The value is stored in every case.
- R9: End-of-interrupt (op 4) copies swData[31:24] into the processor priority and pulses eoiValid with swData[23:0]. If nothing is pending it also pulses resendReq and performs the IPI check of R7 against the restored priority.
- R10: Poll (op 5) returns the status word and the IPI priority and changes no state.
- R11: A request that arrives in the same cycle as op 1, 2, 3 or 4 is returned on the bounce channel with its number and owner, and it has no effect on the state. With op 0 or op 5 the request is handled normally.
- R12: Reject, bounce, EOI, resend and read strobes last exactly one cycle, in the cycle after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| reqValid | input | 1 | source side offers an interrupt |
| reqSource | input | 24 | offered source number |
| reqPrio | input | 8 | offered priority |
| reqOwner | input | 2 | id of the offering source-side unit |
| swOp | input | 3 | 0 none, 1 accept, 2 set priority, 3 set IPI priority, 4 EOI, 5 poll |
| swData | input | 32 | operand of the software operation |
| irqOut | output | 1 | level interrupt to the processor |
| rdValid | output | 1 | read data valid (accept or poll) |
| rdData | output | 32 | status word before the operation |
| rdIpiPrio | output | 8 | IPI priority before the operation |
| rejValid | output | 1 | reject strobe |
| rejSource | output | 24 | rejected source number |
| rejOwner | output | 2 | owner of the rejected source |
| bounceValid | output | 1 | request refused because of a colliding operation |
| bounceSource | output | 24 | bounced source number |
| bounceOwner | output | 2 | owner of the bounced source |
| eoiValid | output | 1 | end-of-interrupt strobe to the source side |
| eoiSource | output | 24 | source number being ended |
| resendReq | output | 1 | asks the source side to replay rejected sources |

## Verification
Requests are offered in three situations: against an idle presenter, against a more favoured pending source, and against a less favoured pending source. The last two separate the displacement path from the path where the held source is kept. An equal-priority offer tests the inclusive boundary of both reject comparisons. Priority writes go down past, down short of, equal to and above the pending priority. This separates the reject-and-clear case, the plain update and the resend. IPI writes are checked with owned and unowned pending sources, to show that only owned ones are rejected. Last, a request is collided with a state-changing operation and with a poll, to show bounce and pass-through.

// File: rtl/intPresenterPkg.sv
package intPresenterPkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_ACCEPT   = 3'd1,
    OP_SET_PRIO = 3'd2,
    OP_SET_IPI  = 3'd3,
    OP_EOI      = 3'd4,
    OP_POLL     = 3'd5
  } swOpE;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic capture;     // latch status word and IPI priority for readback
    logic accept;      // processor priority <= pending priority
    logic clearPend;   // drop pending source, lower line
    logic setCppr;     // processor priority <= low byte of swData
    logic eoiCppr;     // processor priority <= top byte of swData
    logic setIpi;      // IPI priority <= low byte of swData
    logic rejPending;  // reject the held source to its owner
    logic rejIncoming; // reject the offered source
    logic bounce;      // refuse the offered source due to collision
    logic loadReq;     // hold the offered source
    logic loadIpi;     // hold the IPI
    logic eoi;         // send end-of-interrupt
    logic resend;      // ask for replay
  } ctlStrobeT;

endpackage

// File: rtl/intPresenterCtl.sv
module intPresenterCtl
  import intPresenterPkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int WORD_W = 32
) (
  input  logic [2:0]        swOp,
  input  logic [WORD_W-1:0] swData,
  input  logic              reqValid,
  input  logic [PRIO_W-1:0] reqPrio,
  input  logic [PRIO_W-1:0] cppr,
  input  logic [PRIO_W-1:0] pendPrio,
  input  logic [PRIO_W-1:0] ipiPrio,
  input  logic              srcBusy,
  input  logic              ownValid,
  output ctlStrobeT         st
);

  swOpE              opE;
  logic              opBusy;
  logic [PRIO_W-1:0] newPrio;
  logic [PRIO_W-1:0] eoiPrio;

  assign opE     = swOpE'(swOp);
  assign newPrio = swData[PRIO_W-1:0];
  assign eoiPrio = swData[WORD_W-1 -: PRIO_W];
  assign opBusy  = (opE == OP_ACCEPT) || (opE == OP_SET_PRIO) ||
                   (opE == OP_SET_IPI) || (opE == OP_EOI);

  always_comb begin
    st = '0;
    unique case (opE)
      OP_ACCEPT: begin
        st.capture   = 1'b1;
        st.accept    = 1'b1;
        st.clearPend = 1'b1;
      end
      OP_POLL: st.capture = 1'b1;
      OP_SET_PRIO: begin
        st.setCppr = 1'b1;
        if (newPrio < cppr) begin
          if (srcBusy && (newPrio <= pendPrio)) begin
            st.clearPend  = 1'b1;
            st.rejPending = ownValid;
          end
        end else if (!srcBusy) begin
          st.resend  = 1'b1;
          st.loadIpi = (ipiPrio < newPrio);
        end
      end
      OP_SET_IPI: begin
        st.setIpi = 1'b1;
        if ((newPrio < cppr) && !(srcBusy && (pendPrio <= newPrio))) begin
          st.loadIpi    = 1'b1;
          st.rejPending = srcBusy && ownValid;
        end
      end
      OP_EOI: begin
        st.eoiCppr = 1'b1;
        st.eoi     = 1'b1;
        if (!srcBusy) begin
          st.resend  = 1'b1;
          st.loadIpi = (ipiPrio < eoiPrio);
        end
      end
      default: ;
    endcase

    if (reqValid) begin
      if (opBusy) begin
        st.bounce = 1'b1;
      end else if ((reqPrio >= cppr) || (srcBusy && (pendPrio <= reqPrio))) begin
        st.rejIncoming = 1'b1;
      end else begin
        st.loadReq    = 1'b1;
        st.rejPending = srcBusy && ownValid;
      end
    end
  end

endmodule

// File: rtl/intPresenterDp.sv
module intPresenterDp
  import intPresenterPkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int OWNER_W = 2,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobeT                 st,
  input  logic [PRIO_W+SRC_W-1:0]   swData,
  input  logic [SRC_W-1:0]          reqSource,
  input  logic [PRIO_W-1:0]         reqPrio,
  input  logic [OWNER_W-1:0]        reqOwner,
  output logic [PRIO_W-1:0]         cppr,
  output logic [SRC_W-1:0]          srcNum,
  output logic [PRIO_W-1:0]         pendPrio,
  output logic [PRIO_W-1:0]         ipiPrio,
  output logic                      ownValid,
  output logic                      srcBusy,
  output logic                      irqOut,
  output logic                      rdValid,
  output logic [PRIO_W+SRC_W-1:0]   rdData,
  output logic [PRIO_W-1:0]         rdIpiPrio,
  output logic                      rejValid,
  output logic [SRC_W-1:0]          rejSource,
  output logic [OWNER_W-1:0]        rejOwner,
  output logic                      bounceValid,
  output logic [SRC_W-1:0]          bounceSource,
  output logic [OWNER_W-1:0]        bounceOwner,
  output logic                      eoiValid,
  output logic [SRC_W-1:0]          eoiSource,
  output logic                      resendReq
);

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);

  logic [OWNER_W-1:0] owner;
  logic [PRIO_W-1:0]  ipiEff;

  assign srcBusy = (srcNum != '0);
  assign ipiEff  = st.setIpi ? swData[PRIO_W-1:0] : ipiPrio;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cppr         <= '0;
      srcNum       <= '0;
      pendPrio     <= LEAST;
      ipiPrio      <= LEAST;
      ownValid     <= 1'b0;
      owner        <= '0;
      irqOut       <= 1'b0;
      rdValid      <= 1'b0;
      rdData       <= '0;
      rdIpiPrio    <= '0;
      rejValid     <= 1'b0;
      rejSource    <= '0;
      rejOwner     <= '0;
      bounceValid  <= 1'b0;
      bounceSource <= '0;
      bounceOwner  <= '0;
      eoiValid     <= 1'b0;
      eoiSource    <= '0;
      resendReq    <= 1'b0;
    end else begin
      rdValid     <= st.capture;
      rejValid    <= st.rejPending | st.rejIncoming;
      bounceValid <= st.bounce;
      eoiValid    <= st.eoi;
      resendReq   <= st.resend;

      if (st.capture) begin
        rdData    <= {cppr, srcNum};
        rdIpiPrio <= ipiPrio;
      end
      if (st.rejIncoming) begin
        rejSource <= reqSource;
        rejOwner  <= reqOwner;
      end else if (st.rejPending) begin
        rejSource <= srcNum;
        rejOwner  <= owner;
      end
      if (st.bounce) begin
        bounceSource <= reqSource;
        bounceOwner  <= reqOwner;
      end
      if (st.eoi) eoiSource <= swData[SRC_W-1:0];

      if (st.accept)       cppr <= pendPrio;
      else if (st.setCppr) cppr <= swData[PRIO_W-1:0];
      else if (st.eoiCppr) cppr <= swData[WORD_W-1 -: PRIO_W];
      if (st.setIpi) ipiPrio <= swData[PRIO_W-1:0];

      if (st.loadReq) begin
        srcNum   <= reqSource;
        pendPrio <= reqPrio;
        ownValid <= 1'b1;
        owner    <= reqOwner;
        irqOut   <= 1'b1;
      end else if (st.loadIpi) begin
        srcNum   <= IPI_NUM;
        pendPrio <= ipiEff;
        ownValid <= 1'b0;
        irqOut   <= 1'b1;
      end else if (st.clearPend) begin
        srcNum   <= '0;
        pendPrio <= LEAST;
        ownValid <= 1'b0;
        irqOut   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/intPresenter.sv
module intPresenter
  import intPresenterPkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int OWNER_W = 2,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [SRC_W-1:0]         reqSource,
  input  logic [PRIO_W-1:0]        reqPrio,
  input  logic [OWNER_W-1:0]       reqOwner,
  input  logic [2:0]               swOp,
  input  logic [PRIO_W+SRC_W-1:0]  swData,
  output logic                     irqOut,
  output logic                     rdValid,
  output logic [PRIO_W+SRC_W-1:0]  rdData,
  output logic [PRIO_W-1:0]        rdIpiPrio,
  output logic                     rejValid,
  output logic [SRC_W-1:0]         rejSource,
  output logic [OWNER_W-1:0]       rejOwner,
  output logic                     bounceValid,
  output logic [SRC_W-1:0]         bounceSource,
  output logic [OWNER_W-1:0]       bounceOwner,
  output logic                     eoiValid,
  output logic [SRC_W-1:0]         eoiSource,
  output logic                     resendReq
);

  localparam int WORD_W = PRIO_W + SRC_W;

  ctlStrobeT         st;
  logic [PRIO_W-1:0] cppr;
  logic [SRC_W-1:0]  srcNum;
  logic [PRIO_W-1:0] pendPrio;
  logic [PRIO_W-1:0] ipiPrio;
  logic              ownValid;
  logic              srcBusy;

  intPresenterCtl #(.PRIO_W(PRIO_W), .WORD_W(WORD_W)) u_ctl (
    .swOp(swOp), .swData(swData), .reqValid(reqValid), .reqPrio(reqPrio),
    .cppr(cppr), .pendPrio(pendPrio), .ipiPrio(ipiPrio),
    .srcBusy(srcBusy), .ownValid(ownValid), .st(st)
  );

  intPresenterDp #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .OWNER_W(OWNER_W),
                   .IPI_SRC(IPI_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .swData(swData),
    .reqSource(reqSource), .reqPrio(reqPrio), .reqOwner(reqOwner),
    .cppr(cppr), .srcNum(srcNum), .pendPrio(pendPrio), .ipiPrio(ipiPrio),
    .ownValid(ownValid), .srcBusy(srcBusy), .irqOut(irqOut),
    .rdValid(rdValid), .rdData(rdData), .rdIpiPrio(rdIpiPrio),
    .rejValid(rejValid), .rejSource(rejSource), .rejOwner(rejOwner),
    .bounceValid(bounceValid), .bounceSource(bounceSource),
    .bounceOwner(bounceOwner), .eoiValid(eoiValid), .eoiSource(eoiSource),
    .resendReq(resendReq)
  );

endmodule

// File: rtl/intPresenterChk.sv
module intPresenterChk
  import intPresenterPkg::*;
#(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        swOp,
  input logic              reqValid,
  input logic              irqOut,
  input logic [SRC_W-1:0]  srcNum,
  input logic [PRIO_W-1:0] pendPrio,
  input logic              eoiValid,
  input logic              bounceValid,
  input logic              rdValid
);

  logic opBusy;
  assign opBusy = (swOp == OP_ACCEPT) || (swOp == OP_SET_PRIO) ||
                  (swOp == OP_SET_IPI) || (swOp == OP_EOI);

  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (srcNum != '0));

  // R2
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcNum == '0) |-> (pendPrio == '1));

  // R5
  accept_lowers_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swOp == OP_ACCEPT) |=> !irqOut);

  // R9
  eoi_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swOp == OP_EOI) |=> eoiValid);

  // R12
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swOp != OP_EOI) |=> !eoiValid);

  // R10
  poll_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((swOp == OP_POLL) && !reqValid) |=> ($stable(srcNum) && $stable(pendPrio)));

  // R11
  bounce_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opBusy) |=> bounceValid);

  // R10
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((swOp == OP_POLL) || (swOp == OP_ACCEPT)) |=> rdValid);

endmodule

bind intPresenter intPresenterChk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rstN(rstN), .swOp(swOp), .reqValid(reqValid), .irqOut(irqOut),
  .srcNum(srcNum), .pendPrio(pendPrio), .eoiValid(eoiValid),
  .bounceValid(bounceValid), .rdValid(rdValid)
);

// File: tb/intPresenter_bench.sv
`timescale 1ns/1ps
module intPresenter_bench;

  localparam logic [2:0] NONE = 3'd0, ACC = 3'd1, SPRIO = 3'd2, SIPI = 3'd3,
                         EOI = 3'd4, POLL = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [23:0] reqSource = '0;
  logic [7:0]  reqPrio = '0;
  logic [1:0]  reqOwner = '0;
  logic [2:0]  swOp = NONE;
  logic [31:0] swData = '0;
  logic        irqOut, rdValid, rejValid, bounceValid, eoiValid, resendReq;
  logic [31:0] rdData;
  logic [7:0]  rdIpiPrio;
  logic [23:0] rejSource, bounceSource, eoiSource;
  logic [1:0]  rejOwner, bounceOwner;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  intPresenter u_intPresenter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSource(reqSource),
    .reqPrio(reqPrio), .reqOwner(reqOwner), .swOp(swOp), .swData(swData),
    .irqOut(irqOut), .rdValid(rdValid), .rdData(rdData), .rdIpiPrio(rdIpiPrio),
    .rejValid(rejValid), .rejSource(rejSource), .rejOwner(rejOwner),
    .bounceValid(bounceValid), .bounceSource(bounceSource),
    .bounceOwner(bounceOwner), .eoiValid(eoiValid), .eoiSource(eoiSource),
    .resendReq(resendReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    reqValid = 1'b0;
    swOp     = NONE;
    swData   = '0;
  endtask

  task automatic sw(input logic [2:0] op, input logic [31:0] d);
    swOp = op; swData = d;
    step();
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p, input logic [1:0] o);
    reqValid = 1'b1; reqSource = s; reqPrio = p; reqOwner = o;
  endtask

  task automatic req(input logic [23:0] s, input logic [7:0] p, input logic [1:0] o);
    offer(s, p, o);
    step();
  endtask

  task automatic pollChk(input string tag, input logic [31:0] w, input logic [7:0] ipi);
    sw(POLL, '0);
    chk({tag, " poll valid"}, 32'(rdValid), 32'd1);
    chk({tag, " poll word"}, rdData, w);
    chk({tag, " poll ipi"}, 32'(rdIpiPrio), 32'(ipi));
  endtask

  task automatic testReset();
    chk("R1 irq low", 32'(irqOut), 0);
    pollChk("R1 reset", 32'h0000_0000, 8'hFF);
    sw(ACC, '0);
    chk("R1 accept after reset", rdData, 32'h0);
    pollChk("R1 pending prio", 32'hFF00_0000, 8'hFF);
  endtask

  task automatic testPresent();
    req(24'h10, 8'd5, 2'd1);
    chk("R3 no reject", 32'(rejValid), 0);
    chk("R3 irq high", 32'(irqOut), 1);
    pollChk("R3 latched", 32'hFF00_0010, 8'hFF);
    req(24'h20, 8'd3, 2'd2);
    chk("R3 displace reject", 32'(rejValid), 1);
    chk("R3 displaced number", 32'(rejSource), 32'h10);
    chk("R3 displaced owner", 32'(rejOwner), 1);
    pollChk("R3 new pending", 32'hFF00_0020, 8'hFF);
  endtask

  task automatic testReject();
    req(24'h30, 8'd3, 2'd0);
    chk("R4 equal pend reject", 32'(rejValid), 1);
    chk("R4 reject number", 32'(rejSource), 32'h30);
    chk("R4 reject owner", 32'(rejOwner), 0);
    pollChk("R4 unchanged", 32'hFF00_0020, 8'hFF);
  endtask

  task automatic testAccept();
    sw(ACC, '0);
    chk("R5 old word", rdData, 32'hFF00_0020);
    chk("R5 line low", 32'(irqOut), 0);
    pollChk("R5 after accept", 32'h0300_0000, 8'hFF);
    req(24'h40, 8'd3, 2'd1);
    chk("R4 equal cppr reject", 32'(rejValid), 1);
    chk("R4 reject number cppr", 32'(rejSource), 32'h40);
    req(24'h41, 8'd4, 2'd1);
    chk("R4 above cppr reject", 32'(rejValid), 1);
    chk("R4 line stays low", 32'(irqOut), 0);
    req(24'h42, 8'd1, 2'd2);
    chk("R3 favoured taken", 32'(rejValid), 0);
    pollChk("R3 after accept", 32'h0300_0042, 8'hFF);
  endtask

  task automatic testSetPrio();
    sw(SPRIO, 32'd2);
    chk("R6 short of pend no reject", 32'(rejValid), 0);
    chk("R6 line kept", 32'(irqOut), 1);
    pollChk("R6 plain update", 32'h0200_0042, 8'hFF);
    sw(SPRIO, 32'd1);
    chk("R6 reject", 32'(rejValid), 1);
    chk("R6 reject number", 32'(rejSource), 32'h42);
    chk("R6 reject owner", 32'(rejOwner), 2);
    chk("R6 line low", 32'(irqOut), 0);
    step();
    chk("R12 reject one cycle", 32'(rejValid), 0);
    pollChk("R6 cleared", 32'h0100_0000, 8'hFF);
  endtask

  task automatic testResend();
    sw(SPRIO, 32'd4);
    chk("R7 resend on raise", 32'(resendReq), 1);
    chk("R7 no ipi", 32'(irqOut), 0);
    sw(SPRIO, 32'd4);
    chk("R7 resend on equal", 32'(resendReq), 1);
    sw(SPRIO, 32'd2);
    chk("R7 no resend on lower", 32'(resendReq), 0);
    pollChk("R7 state", 32'h0200_0000, 8'hFF);
  endtask

  task automatic testIpi();
    sw(SIPI, 32'd5);
    chk("R8 not below cppr", 32'(irqOut), 0);
    pollChk("R8 stored", 32'h0200_0000, 8'h05);
    sw(SPRIO, 32'd8);
    chk("R7 resend with ipi", 32'(resendReq), 1);
    chk("R7 ipi raised", 32'(irqOut), 1);
    pollChk("R7 ipi pending", 32'h0800_0002, 8'h05);
    sw(ACC, '0);
    chk("R5 ipi accepted", rdData, 32'h0800_0002);
    sw(SIPI, 32'hFF);
    chk("R8 ff no load", 32'(irqOut), 0);
    req(24'h50, 8'd2, 2'd3);
    chk("R3 taken under 5", 32'(irqOut), 1);
    sw(SIPI, 32'd1);
    chk("R8 owned rejected", 32'(rejValid), 1);
    chk("R8 rejected number", 32'(rejSource), 32'h50);
    chk("R8 rejected owner", 32'(rejOwner), 3);
    pollChk("R8 ipi displaces", 32'h0500_0002, 8'h01);
    sw(SIPI, 32'd3);
    chk("R8 blocked no reject", 32'(rejValid), 0);
    pollChk("R8 blocked", 32'h0500_0002, 8'h03);
    req(24'h60, 8'd0, 2'd1);
    chk("R3 ipi dropped silently", 32'(rejValid), 0);
    pollChk("R3 over ipi", 32'h0500_0060, 8'h03);
  endtask

  task automatic testEoi();
    sw(EOI, 32'h0700_0060);
    chk("R9 eoi strobe", 32'(eoiValid), 1);
    chk("R9 eoi number", 32'(eoiSource), 32'h60);
    chk("R9 no resend busy", 32'(resendReq), 0);
    pollChk("R9 prio restored", 32'h0700_0060, 8'h03);
    sw(ACC, '0);
    chk("R5 accept before eoi", rdData, 32'h0700_0060);
    sw(EOI, 32'h0600_0123);
    chk("R9 eoi number idle", 32'(eoiSource), 32'h123);
    chk("R9 resend idle", 32'(resendReq), 1);
    chk("R9 ipi check", 32'(irqOut), 1);
    step();
    chk("R12 eoi one cycle", 32'(eoiValid), 0);
    pollChk("R9 ipi pending", 32'h0600_0002, 8'h03);
  endtask

  task automatic testPoll();
    sw(POLL, '0);
    chk("R10 first", rdData, 32'h0600_0002);
    chk("R10 no reject", 32'(rejValid), 0);
    chk("R10 no resend", 32'(resendReq), 0);
    sw(POLL, '0);
    chk("R10 second same", rdData, 32'h0600_0002);
    chk("R10 line kept", 32'(irqOut), 1);
  endtask

  task automatic testCollide();
    offer(24'h70, 8'd0, 2'd2);
    sw(SIPI, 32'hFF);
    chk("R11 bounce", 32'(bounceValid), 1);
    chk("R11 bounce number", 32'(bounceSource), 32'h70);
    chk("R11 bounce owner", 32'(bounceOwner), 2);
    chk("R11 no reject", 32'(rejValid), 0);
    pollChk("R11 untouched", 32'h0600_0002, 8'hFF);
    offer(24'h71, 8'd1, 2'd1);
    sw(POLL, '0);
    chk("R11 poll sees old", rdData, 32'h0600_0002);
    chk("R11 poll no bounce", 32'(bounceValid), 0);
    chk("R11 poll no reject", 32'(rejValid), 0);
    pollChk("R11 passed through", 32'h0600_0071, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPresent();
    testReject();
    testAccept();
    testSetPrio();
    testResend();
    testIpi();
    testEoi();
    testPoll();
    testCollide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule